// File: doc/BRIEF.md
# Frame-Synchronized Serial Port

This block is a slave-mode synchronous serial port with independent receive and transmit channels. Each channel is paced by a bit clock and a frame-sync pulse that arrive from outside the block, and each frame carries exactly one 16-bit word. A host working in its own clock domain exchanges words with the port through a read register and a write register. It polls a ready flag on each side before it accesses the register.

All serial pins pass through a two-flop synchronizer with edge detection into the host clock. The channel logic therefore runs entirely on the host clock and acts on one-cycle edge events. The receiver acts on falling edges of its bit clock. The transmitter acts on rising edges of its bit clock. Both use a one-bit data delay: the first data bit falls in the bit period after the one in which the frame sync was seen. A frame sync that arrives while a word is still being shifted has no effect.

The receiver reports an overrun when it completes a word that the host has no room for. The transmitter reports an underrun when a frame starts and no new word has been written, and it then sends the previous word again.

Top module: `ssp_port`

## Requirements
- R1: While reset is low, and afterwards until the first serial event, rx_ready, rx_overrun and tx_underrun read 0, tx_ready reads 1 and tx_sdata reads 0.
- R2: When the receiver sees rx_fsync high at a falling edge of rx_sclk and is idle, it samples rx_sdata at the 16 falling edges that follow, most significant bit first. It then places the word on rd_data and sets rx_ready.
- R3: A one-cycle pulse on rd_strobe clears rx_ready and rx_overrun, unless a word completes in that same cycle.
- R4: If a word completes while rx_ready is set and rd_strobe is low, the word is discarded, rd_data keeps its value, rx_ready stays set and rx_overrun is set.
- R5: If a word completes in the same host cycle as an rd_strobe pulse, the new word is stored, rx_ready stays 1 and rx_overrun reads 0.
- R6: On either channel, a frame sync that arrives while a word is being shifted is ignored, and the word in progress completes unchanged.
- R7: When the transmitter sees tx_fsync high at a rising edge of tx_sclk and is idle, it drives the loaded word on tx_sdata at the 16 rising edges that follow, most significant bit first.
- R8: A wr_strobe pulse stores wr_data and clears tx_ready and tx_underrun. Loading a written word at a frame start sets tx_ready again.
- R9: If a transmit frame starts while tx_ready is 1 and wr_strobe is low, the previously written word is sent again and tx_underrun is set.
- R10: Outside the 16 bit periods of a word, tx_sdata is 0.
- R11: A serial pin change takes effect in the third host clock edge after it is applied, and each serial clock edge produces a single one-cycle event.
- R12: If wr_strobe falls in the same host cycle as a transmit frame start, wr_data itself is sent, tx_ready stays 1 and tx_underrun reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_sdata | input | 1 | Receive serial data |
| rd_strobe | input | 1 | Host read pulse, one cycle |
| rd_data | output | DATA_W | Last accepted receive word |
| rx_ready | output | 1 | A received word is waiting |
| rx_overrun | output | 1 | A word was dropped because the previous one was unread |
| tx_sclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| wr_strobe | input | 1 | Host write pulse, one cycle |
| wr_data | input | DATA_W | Word to transmit |
| tx_sdata | output | 1 | Transmit serial data |
| tx_ready | output | 1 | Write register may take a new word |
| tx_underrun | output | 1 | A frame started without a fresh word |

## Verification
A host read can land in the same host cycle as the completion of a received word. A host write can land in the same cycle as a transmit frame start. The bench provokes each case on purpose by counting the three synchronizer stages from the serial clock edge and raising the strobe for exactly that host edge. It judges the result against a behavioural model that tracks the pin history and the flag rules with plain integers. In the receive case, the new word must be kept with no overrun. In the transmit case, the written word must appear on the line with neither underrun nor a stale ready flag.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_SHIFT = 1'b1
    } ch_state_e;
endpackage

// File: rtl/ssp_sync_edge.sv
module ssp_sync_edge #(
    parameter int W       = 1,
    parameter bit FALLING = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_pin_i,
    input  logic [W-1:0] dat_pin_i,
    output logic [W-1:0] dat_o,
    output logic         edge_o
);
    typedef struct packed {
        logic         c1;
        logic         c2;
        logic         c3;
        logic [W-1:0] d1;
        logic [W-1:0] d2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.c1 = clk_pin_i;
        sync_d.c2 = sync_q.c1;
        sync_d.c3 = sync_q.c2;
        sync_d.d1 = dat_pin_i;
        sync_d.d2 = sync_q.d1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = sync_q.c3 & ~sync_q.c2;
        end else begin : g_rise
            assign edge_o = sync_q.c2 & ~sync_q.c3;
        end
    endgenerate

    assign dat_o = sync_q.d2;

    // R11
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/ssp_rx_chan.sv
module ssp_rx_chan
    import ssp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              sdata_i,
    input  logic              fsync_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ready_o,
    output logic              overrun_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        ch_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] word;
        logic              ready;
        logic              ovr;
    } rx_t;

    rx_t  rx_d, rx_q;
    logic done_w;
    logic ready_left;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        rx_d       = rx_q;
        done_w     = 1'b0;
        shifted    = {rx_q.sh[DATA_W-2:0], sdata_i};
        if (fall_i) begin
            if (rx_q.st == CH_SHIFT) begin
                rx_d.sh = shifted;
                if (rx_q.cnt == LAST) begin
                    rx_d.st  = CH_IDLE;
                    rx_d.cnt = '0;
                    done_w   = 1'b1;
                end else begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end else if (fsync_i) begin
                rx_d.st  = CH_SHIFT;
                rx_d.cnt = '0;
            end
        end
        ready_left = rx_q.ready & ~rd_i;
        if (rd_i) begin
            rx_d.ready = 1'b0;
            rx_d.ovr   = 1'b0;
        end
        if (done_w) begin
            if (ready_left) begin
                rx_d.ovr = 1'b1;
            end else begin
                rx_d.word  = shifted;
                rx_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rd_data_o = rx_q.word;
    assign ready_o   = rx_q.ready;
    assign overrun_o = rx_q.ovr;

    // R3
    rd_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done_w) |=> (!ready_o && !overrun_o));
    // R4
    overrun_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !rd_i && done_w) |=> (overrun_o && ready_o && $stable(rd_data_o)));
    // R5
    read_meets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && done_w) |=> (ready_o && !overrun_o));
    // R6
    rx_sync_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.st == CH_SHIFT && fall_i && rx_q.cnt != LAST) |=> (rx_q.st == CH_SHIFT));
endmodule

// File: rtl/ssp_tx_chan.sv
module ssp_tx_chan
    import ssp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fsync_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              sdata_o,
    output logic              ready_o,
    output logic              underrun_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        ch_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] hold;
        logic              ready;
        logic              und;
        logic              sdo;
    } tx_t;

    tx_t  tx_d, tx_q;
    logic load_w;

    always_comb begin
        tx_d   = tx_q;
        load_w = 1'b0;
        if (rise_i) begin
            if (tx_q.st == CH_SHIFT) begin
                tx_d.sdo = tx_q.sh[DATA_W-1];
                tx_d.sh  = {tx_q.sh[DATA_W-2:0], 1'b0};
                if (tx_q.cnt == LAST) begin
                    tx_d.st  = CH_IDLE;
                    tx_d.cnt = '0;
                end else begin
                    tx_d.cnt = tx_q.cnt + 1'b1;
                end
            end else begin
                tx_d.sdo = 1'b0;
                if (fsync_i) begin
                    tx_d.st  = CH_SHIFT;
                    tx_d.cnt = '0;
                    load_w   = 1'b1;
                end
            end
        end
        if (load_w) begin
            tx_d.ready = 1'b1;
            if (wr_i) begin
                tx_d.sh   = wr_data_i;
                tx_d.hold = wr_data_i;
                tx_d.und  = 1'b0;
            end else begin
                tx_d.sh = tx_q.hold;
                if (tx_q.ready) tx_d.und = 1'b1;
            end
        end else if (wr_i) begin
            tx_d.hold  = wr_data_i;
            tx_d.ready = 1'b0;
            tx_d.und   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q       <= '0;
            tx_q.ready <= 1'b1;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sdata_o    = tx_q.sdo;
    assign ready_o    = tx_q.ready;
    assign underrun_o = tx_q.und;

    // R8
    write_takes_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !load_w) |=> (!ready_o && !underrun_o));
    // R9
    stale_frame_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_w && !wr_i && ready_o) |=> (underrun_o && ready_o));
    // R12
    write_meets_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_w && wr_i) |=> (ready_o && !underrun_o));
    // R10
    idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q.st == CH_IDLE && rise_i) |=> !sdata_o);
    // R6
    tx_sync_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q.st == CH_SHIFT && rise_i && tx_q.cnt != LAST) |=> (tx_q.st == CH_SHIFT));
endmodule

// File: rtl/ssp_port.sv
module ssp_port #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sclk,
    input  logic              rx_fsync,
    input  logic              rx_sdata,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              rx_overrun,
    input  logic              tx_sclk,
    input  logic              tx_fsync,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_sdata,
    output logic              tx_ready,
    output logic              tx_underrun
);
    logic [1:0] rx_pins;
    logic       rx_fall;
    logic [0:0] tx_pins;
    logic       tx_rise;

    ssp_sync_edge #(.W(2), .FALLING(1'b1)) u_rx_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_pin_i (rx_sclk),
        .dat_pin_i ({rx_sdata, rx_fsync}),
        .dat_o     (rx_pins),
        .edge_o    (rx_fall)
    );

    ssp_sync_edge #(.W(1), .FALLING(1'b0)) u_tx_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_pin_i (tx_sclk),
        .dat_pin_i (tx_fsync),
        .dat_o     (tx_pins),
        .edge_o    (tx_rise)
    );

    ssp_rx_chan #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (rx_fall),
        .sdata_i   (rx_pins[1]),
        .fsync_i   (rx_pins[0]),
        .rd_i      (rd_strobe),
        .rd_data_o (rd_data),
        .ready_o   (rx_ready),
        .overrun_o (rx_overrun)
    );

    ssp_tx_chan #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (tx_rise),
        .fsync_i    (tx_pins[0]),
        .wr_i       (wr_strobe),
        .wr_data_i  (wr_data),
        .sdata_o    (tx_sdata),
        .ready_o    (tx_ready),
        .underrun_o (tx_underrun)
    );
endmodule

// File: tb/ssp_port_test.sv
`timescale 1ns/1ps
module ssp_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_sclk = 1'b0, rx_fsync = 1'b0, rx_sdata = 1'b0, rd_strobe = 1'b0;
    logic tx_sclk = 1'b0, tx_fsync = 1'b0, wr_strobe = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic rx_ready, rx_overrun, tx_sdata, tx_ready, tx_underrun;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    ssp_port #(.DATA_W(16)) uut (
        .clk(clk), .rst_n(rst_n),
        .rx_sclk(rx_sclk), .rx_fsync(rx_fsync), .rx_sdata(rx_sdata),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun),
        .tx_sclk(tx_sclk), .tx_fsync(tx_fsync), .wr_strobe(wr_strobe),
        .wr_data(wr_data), .tx_sdata(tx_sdata), .tx_ready(tx_ready),
        .tx_underrun(tx_underrun)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference: pin history plus flag rules
    int m_rc[3], m_rd[2], m_rf[2], m_tc[3], m_tf[2];
    int m_ract, m_rcnt, m_rsh, m_rword, m_rready, m_rovr;
    int m_tact, m_tcnt, m_tsh, m_thold, m_tready, m_tund, m_tsdo;

    always @(posedge clk) begin
        int rfall, rbit, rfs, rdone, trise, tfs, tload;
        if (!rst_n) begin
            foreach (m_rc[i]) m_rc[i] = 0;
            foreach (m_tc[i]) m_tc[i] = 0;
            m_rd = '{0, 0}; m_rf = '{0, 0}; m_tf = '{0, 0};
            m_ract = 0; m_rcnt = 0; m_rsh = 0; m_rword = 0; m_rready = 0; m_rovr = 0;
            m_tact = 0; m_tcnt = 0; m_tsh = 0; m_thold = 0; m_tready = 1; m_tund = 0; m_tsdo = 0;
        end else begin
            rfall = (m_rc[2] == 1 && m_rc[1] == 0);
            rbit  = m_rd[1];
            rfs   = m_rf[1];
            trise = (m_tc[2] == 0 && m_tc[1] == 1);
            tfs   = m_tf[1];
            m_rc[2] = m_rc[1]; m_rc[1] = m_rc[0]; m_rc[0] = rx_sclk;
            m_rd[1] = m_rd[0]; m_rd[0] = rx_sdata;
            m_rf[1] = m_rf[0]; m_rf[0] = rx_fsync;
            m_tc[2] = m_tc[1]; m_tc[1] = m_tc[0]; m_tc[0] = tx_sclk;
            m_tf[1] = m_tf[0]; m_tf[0] = tx_fsync;
            rdone = 0;
            if (rfall) begin
                if (m_ract != 0) begin
                    m_rsh = ((m_rsh << 1) | rbit) & 16'hFFFF;
                    m_rcnt++;
                    if (m_rcnt == 16) begin m_ract = 0; rdone = 1; end
                end else if (rfs != 0) begin
                    m_ract = 1; m_rcnt = 0;
                end
            end
            if (rd_strobe) begin m_rready = 0; m_rovr = 0; end
            if (rdone != 0) begin
                if (m_rready != 0) m_rovr = 1;
                else begin m_rword = m_rsh; m_rready = 1; end
            end
            tload = 0;
            if (trise) begin
                if (m_tact != 0) begin
                    m_tsdo = (m_tsh >> 15) & 1;
                    m_tsh = (m_tsh << 1) & 16'hFFFF;
                    m_tcnt++;
                    if (m_tcnt == 16) m_tact = 0;
                end else begin
                    m_tsdo = 0;
                    if (tfs != 0) begin m_tact = 1; m_tcnt = 0; tload = 1; end
                end
            end
            if (tload != 0) begin
                if (wr_strobe) begin
                    m_tsh = wr_data; m_thold = wr_data; m_tready = 1; m_tund = 0;
                end else begin
                    m_tsh = m_thold;
                    if (m_tready != 0) m_tund = 1;
                    m_tready = 1;
                end
            end else if (wr_strobe) begin
                m_thold = wr_data; m_tready = 0; m_tund = 0;
            end
        end
    end

    // R11: every host cycle, outputs follow the model with its three-stage pin timing
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check("R11 model rd_data", rd_data, m_rword);
            check("R11 model rx_ready", rx_ready, m_rready);
            check("R11 model rx_overrun", rx_overrun, m_rovr);
            check("R11 model tx_sdata", tx_sdata, m_tsdo);
            check("R11 model tx_ready", tx_ready, m_tready);
            check("R11 model tx_underrun", tx_underrun, m_tund);
        end
    end

    task automatic rx_bit(input logic fs, input logic b);
        rx_sclk = 1'b1; rx_fsync = fs; rx_sdata = b;
        repeat (4) @(negedge clk);
        rx_sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [15:0] w, input int fs_at, input bit rd_end, input bit lat);
        rx_bit(1'b1, 1'b0);
        for (int b = 0; b < 15; b++) rx_bit(b == fs_at, w[15-b]);
        rx_sclk = 1'b1; rx_fsync = 1'b0; rx_sdata = w[0];
        repeat (4) @(negedge clk);
        rx_sclk = 1'b0;
        @(negedge clk);
        if (lat) check("R11 not yet after one edge", rx_ready, 1'b0);
        @(negedge clk);
        if (lat) check("R11 not yet after two edges", rx_ready, 1'b0);
        if (rd_end) rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        if (lat) check("R11 ready at third edge", rx_ready, 1'b1);
        @(negedge clk);
        rx_bit(1'b0, 1'b0);
        rx_bit(1'b0, 1'b0);
    endtask

    task automatic host_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_write(input logic [15:0] w);
        wr_data = w; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic tx_bit(input logic fs, input bit wr_now, input logic [15:0] wv, output logic seen);
        tx_fsync = fs; tx_sclk = 1'b0;
        repeat (4) @(negedge clk);
        tx_sclk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (wr_now) begin wr_data = wv; wr_strobe = 1'b1; end
        @(negedge clk);
        wr_strobe = 1'b0;
        @(negedge clk);
        seen = tx_sdata;
    endtask

    task automatic tx_frame(input logic [15:0] exp, input int fs_at, input bit wr_start, input string tag);
        logic [15:0] got;
        logic s;
        tx_bit(1'b1, wr_start, exp, s);
        check("R10 line low in sync period", s, 1'b0);
        for (int b = 0; b < 16; b++) begin
            tx_bit(b == fs_at, 1'b0, 16'h0, s);
            got[15-b] = s;
        end
        check(tag, got, exp);
        tx_bit(1'b0, 1'b0, 16'h0, s);
        check("R10 line low after word", s, 1'b0);
        tx_bit(1'b0, 1'b0, 16'h0, s);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected finish");
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1 rx_ready in reset", rx_ready, 1'b0);
        check("R1 tx_ready in reset", tx_ready, 1'b1);
        check("R1 tx_sdata in reset", tx_sdata, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 rx_overrun after reset", rx_overrun, 1'b0);
        check("R1 tx_underrun after reset", tx_underrun, 1'b0);

        rx_frame(16'hA5C3, -1, 1'b0, 1'b1);
        check("R2 word received", rd_data, 16'hA5C3);
        check("R2 ready set", rx_ready, 1'b1);
        host_read();
        check("R3 read clears ready", rx_ready, 1'b0);

        rx_frame(16'h1234, -1, 1'b0, 1'b0);
        rx_frame(16'hBEEF, -1, 1'b0, 1'b0);
        check("R4 overrun set", rx_overrun, 1'b1);
        check("R4 old word kept", rd_data, 16'h1234);
        host_read();
        check("R3 read clears overrun", rx_overrun, 1'b0);
        check("R3 read clears ready again", rx_ready, 1'b0);

        rx_frame(16'h0F0F, 5, 1'b0, 1'b0);
        check("R6 rx mid-word sync ignored", rd_data, 16'h0F0F);
        rx_frame(16'h8001, -1, 1'b1, 1'b0);
        check("R5 same-cycle word kept", rd_data, 16'h8001);
        check("R5 ready held", rx_ready, 1'b1);
        check("R5 no overrun", rx_overrun, 1'b0);
        host_read();

        host_write(16'hC35A);
        check("R8 write clears tx_ready", tx_ready, 1'b0);
        tx_frame(16'hC35A, -1, 1'b0, "R7 word shifted out");
        check("R8 ready after load", tx_ready, 1'b1);
        check("R8 no underrun", tx_underrun, 1'b0);
        tx_frame(16'hC35A, -1, 1'b0, "R9 previous word resent");
        check("R9 underrun set", tx_underrun, 1'b1);
        host_write(16'h6B2D);
        check("R8 write clears underrun", tx_underrun, 1'b0);
        tx_frame(16'h6B2D, 7, 1'b0, "R6 tx mid-word sync ignored");
        tx_frame(16'h9E11, -1, 1'b1, "R12 same-cycle word sent");
        check("R12 tx_ready held", tx_ready, 1'b1);
        check("R12 no underrun", tx_underrun, 1'b0);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule